// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Decoder

This block sits in front of the priority resolver of one eight-level interrupt controller. It takes byte writes and reads on a two-address port, where a single address bit picks the register group. It steps through the initialization word sequence and decodes the operation commands: end-of-interrupt variants, priority rotation, the mask, the read selection and poll. It also returns status bytes on reads.

Toward the resolver core it drives a one-cycle reset strobe and holds the configuration registers: mask, vector base, nesting and auto-EOI flags, rotate-on-auto-EOI, special mask and the priority offset. It also sends one-hot strobes that clear in-service and request bits. The core reports back three things: its request and in-service registers, the highest-priority pending level, and the highest-priority in-service level. Writes take effect at the clock edge where the strobe is sampled. Read data and clear strobes appear in the following cycle.

Top module: `pic_cmd_ctrl`

## Requirements
- R1: A write with `a0`=0 and data bit 4 set starts initialization. One cycle later `core_init` is high for exactly one cycle, and mask, priority offset, special mask and read select (to request) are zero. Data bit 0 records whether a fourth word follows; if it is 0, the nesting and auto-EOI flags are cleared.
- R2: After initialization starts, the first `a0`=1 write stores the vector base as data AND 0xF8. The second is a cascade word with no effect on any output. If a fourth word was requested, the third sets the nesting flag from data bit 4 and auto-EOI from data bit 1. The decoder then returns to normal operation.
- R3: In normal operation an `a0`=1 write loads the mask.
- R4: A write with `a0`=0, bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. Bit 1 enables a read-select update, with bit 0 choosing in-service (1) or request (0). Bit 6 enables loading the special mask from bit 5.
- R5: For other `a0`=0 writes, bits 7:5 form an opcode. Opcode 0 clears and opcode 4 sets rotate-on-auto-EOI. Opcode 2 changes nothing.
- R6: Opcode 1 is a non-specific EOI: if `isr_top_vld` is high, `isr_clr` is one-hot at `isr_top_lvl` for one cycle; otherwise it stays zero. Opcode 5 does the same and also sets the offset to that level plus 1, modulo 8.
- R7: Opcode 3 pulses `isr_clr` one-hot at level bits 2:0. Opcode 7 does the same and also sets the offset to that level plus 1, modulo 8.
- R8: Opcode 6 sets the offset to bits 2:0 plus 1, modulo 8, without clearing anything.
- R9: When poll is not armed, `rdata` in the cycle after a read is the mask for `a0`=1. For `a0`=0 it is `core_isr` or `core_irr` according to the read select.
- R10: A read while poll is armed, with `req_vld` high, returns 0x80 OR `req_lvl` and pulses `irr_clr` and `isr_clr` one-hot at that level. With `req_vld` low it returns 0x07 and clears nothing. In both cases poll is disarmed after that one read.
- R11: After reset, `rdata`, mask, vector base, offset, all flags and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| a0 | input | 1 | Register group select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| core_init | output | 1 | One-cycle reset pulse to the resolver core |
| mask_o | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| sfnm_en | output | 1 | Special fully nested mode |
| aeoi_en | output | 1 | Automatic end of interrupt |
| rot_aeoi_en | output | 1 | Rotate on automatic end of interrupt |
| spec_mask_en | output | 1 | Special mask mode |
| prio_ofs | output | 3 | Lowest-numbered level that has top priority |
| isr_clr | output | 8 | One-cycle in-service clear strobes |
| irr_clr | output | 8 | One-cycle request clear strobes |
| core_irr | input | 8 | Request register from the core |
| core_isr | input | 8 | In-service register from the core |
| req_vld | input | 1 | A pending level wins arbitration |
| req_lvl | input | 3 | Winning pending level |
| isr_top_vld | input | 1 | Some level is in service |
| isr_top_lvl | input | 3 | Highest-priority in-service level |

## Verification
The main decode path is exercised with every opcode of bits 7:5. Each run pairs a level field chosen to reveal a wrong slice or a missing wrap, such as level 7 making the offset wrap to 0. The initialization path runs both with and without the fourth word. This separates a decoder that returns to normal after the cascade word from one that consumes one word too many, and it confirms that a mask write in the middle of the sequence is not taken as a mask. Poll is tried with and without a pending level and followed by a second read, which distinguishes the one-shot poll status from an ordinary mask or in-service read.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    localparam int DW = 8;
    localparam int LW = 3;
    localparam int NL = 1 << LW;
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(NL - 1);
    localparam logic [DW-1:0] POLL_IDLE = DW'(NL - 1);

    typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_st_e;

    typedef enum logic [2:0] {
        OP_ROT_CLR = 3'd0,
        OP_EOI     = 3'd1,
        OP_NOP     = 3'd2,
        OP_SEOI    = 3'd3,
        OP_ROT_SET = 3'd4,
        OP_REOI    = 3'd5,
        OP_PRIO    = 3'd6,
        OP_RSEOI   = 3'd7
    } op_e;

    typedef struct packed {
        init_st_e        st;
        logic            init4;
        logic [DW-1:0]   mask;
        logic [DW-1:0]   base;
        logic            sfnm;
        logic            aeoi;
        logic            rot;
        logic            smm;
        logic            rsel;
        logic            poll;
        logic [LW-1:0]   ofs;
        logic            core_init;
        logic [NL-1:0]   isr_clr;
        logic [NL-1:0]   irr_clr;
        logic [DW-1:0]   rdata;
    } ctl_s;

    function automatic logic [NL-1:0] lvl_bit(input logic [LW-1:0] l);
        logic [NL-1:0] r;
        r = '0;
        r[l] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          wr_en,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  init_st_e      st_q,
    input  logic          init4_q,
    output logic          icw1_hit,
    output init_st_e      st_d,
    output logic          base_ld,
    output logic          mode_ld,
    output logic          mask_ld
);
    always_comb begin
        icw1_hit = wr_en && !a0 && wdata[4];
        st_d     = st_q;
        base_ld  = 1'b0;
        mode_ld  = 1'b0;
        mask_ld  = 1'b0;
        if (icw1_hit) begin
            st_d = ST_BASE;
        end else if (wr_en && a0) begin
            case (st_q)
                ST_RUN:  mask_ld = 1'b1;
                ST_BASE: begin
                    base_ld = 1'b1;
                    st_d    = ST_CASC;
                end
                ST_CASC: st_d = init4_q ? ST_MODE : ST_RUN;
                ST_MODE: begin
                    mode_ld = 1'b1;
                    st_d    = ST_RUN;
                end
                default: st_d = ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_cmd_pkg::*;
(
    input  logic          wr_en,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic          isr_top_vld,
    input  logic [LW-1:0] isr_top_lvl,
    output logic          poll_arm,
    output logic          rsel_ld,
    output logic          rsel_val,
    output logic          smm_ld,
    output logic          smm_val,
    output logic          rot_ld,
    output logic          rot_val,
    output logic          ofs_ld,
    output logic [LW-1:0] ofs_val,
    output logic          eoi_vld,
    output logic [LW-1:0] eoi_lvl
);
    logic          cmd_wr;
    logic          mode_cmd;
    logic          op_cmd;
    op_e           op;
    logic [LW-1:0] fld_lvl;

    assign cmd_wr   = wr_en && !a0 && !wdata[4];
    assign mode_cmd = cmd_wr && wdata[3];
    assign op_cmd   = cmd_wr && !wdata[3];
    assign op       = op_e'(wdata[7:5]);
    assign fld_lvl  = wdata[LW-1:0];

    always_comb begin
        poll_arm = mode_cmd && wdata[2];
        rsel_ld  = mode_cmd && wdata[1];
        rsel_val = wdata[0];
        smm_ld   = mode_cmd && wdata[6];
        smm_val  = wdata[5];
        rot_ld   = 1'b0;
        rot_val  = 1'b0;
        ofs_ld   = 1'b0;
        ofs_val  = '0;
        eoi_vld  = 1'b0;
        eoi_lvl  = '0;
        if (op_cmd) begin
            case (op)
                OP_ROT_CLR, OP_ROT_SET: begin
                    rot_ld  = 1'b1;
                    rot_val = (op == OP_ROT_SET);
                end
                OP_EOI, OP_REOI: begin
                    if (isr_top_vld) begin
                        eoi_vld = 1'b1;
                        eoi_lvl = isr_top_lvl;
                        ofs_ld  = (op == OP_REOI);
                        ofs_val = isr_top_lvl + LW'(1);
                    end
                end
                OP_SEOI, OP_RSEOI: begin
                    eoi_vld = 1'b1;
                    eoi_lvl = fld_lvl;
                    ofs_ld  = (op == OP_RSEOI);
                    ofs_val = fld_lvl + LW'(1);
                end
                OP_PRIO: begin
                    ofs_ld  = 1'b1;
                    ofs_val = fld_lvl + LW'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_read_path.sv
module pic_read_path
    import pic_cmd_pkg::*;
(
    input  logic          a0,
    input  logic          poll_q,
    input  logic          rsel_q,
    input  logic [DW-1:0] irr,
    input  logic [DW-1:0] isr,
    input  logic [DW-1:0] mask,
    input  logic          req_vld,
    input  logic [LW-1:0] req_lvl,
    output logic [DW-1:0] rd_val,
    output logic [NL-1:0] poll_clr
);
    always_comb begin
        rd_val   = '0;
        poll_clr = '0;
        if (poll_q) begin
            if (req_vld) begin
                rd_val[DW-1]   = 1'b1;
                rd_val[LW-1:0] = req_lvl;
                poll_clr       = lvl_bit(req_lvl);
            end else begin
                rd_val = POLL_IDLE;
            end
        end else if (a0) begin
            rd_val = mask;
        end else begin
            rd_val = rsel_q ? isr : irr;
        end
    end
endmodule

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          a0,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          core_init,
    output logic [7:0]    mask_o,
    output logic [7:0]    vec_base,
    output logic          sfnm_en,
    output logic          aeoi_en,
    output logic          rot_aeoi_en,
    output logic          spec_mask_en,
    output logic [2:0]    prio_ofs,
    output logic [7:0]    isr_clr,
    output logic [7:0]    irr_clr,
    input  logic [7:0]    core_irr,
    input  logic [7:0]    core_isr,
    input  logic          req_vld,
    input  logic [2:0]    req_lvl,
    input  logic          isr_top_vld,
    input  logic [2:0]    isr_top_lvl
);
    ctl_s q, d;

    logic          icw1_hit, base_ld, mode_ld, mask_ld;
    init_st_e      st_d;
    logic          poll_arm, rsel_ld, rsel_val, smm_ld, smm_val;
    logic          rot_ld, rot_val, ofs_ld, eoi_vld;
    logic [LW-1:0] ofs_val, eoi_lvl;
    logic [DW-1:0] rd_val;
    logic [NL-1:0] poll_clr;
    init_st_e      st_cur;
    logic          poll_armed;

    pic_init_seq u_seq (
        .wr_en    (wr_en),
        .a0       (a0),
        .wdata    (wdata),
        .st_q     (q.st),
        .init4_q  (q.init4),
        .icw1_hit (icw1_hit),
        .st_d     (st_d),
        .base_ld  (base_ld),
        .mode_ld  (mode_ld),
        .mask_ld  (mask_ld)
    );

    pic_cmd_decode u_dec (
        .wr_en       (wr_en),
        .a0          (a0),
        .wdata       (wdata),
        .isr_top_vld (isr_top_vld),
        .isr_top_lvl (isr_top_lvl),
        .poll_arm    (poll_arm),
        .rsel_ld     (rsel_ld),
        .rsel_val    (rsel_val),
        .smm_ld      (smm_ld),
        .smm_val     (smm_val),
        .rot_ld      (rot_ld),
        .rot_val     (rot_val),
        .ofs_ld      (ofs_ld),
        .ofs_val     (ofs_val),
        .eoi_vld     (eoi_vld),
        .eoi_lvl     (eoi_lvl)
    );

    pic_read_path u_rd (
        .a0       (a0),
        .poll_q   (q.poll),
        .rsel_q   (q.rsel),
        .irr      (core_irr),
        .isr      (core_isr),
        .mask     (q.mask),
        .req_vld  (req_vld),
        .req_lvl  (req_lvl),
        .rd_val   (rd_val),
        .poll_clr (poll_clr)
    );

    always_comb begin
        d           = q;
        d.core_init = 1'b0;
        d.isr_clr   = '0;
        d.irr_clr   = '0;
        d.st        = st_d;

        if (icw1_hit) begin
            d.init4     = wdata[0];
            d.mask      = '0;
            d.ofs       = '0;
            d.smm       = 1'b0;
            d.rsel      = 1'b0;
            d.core_init = 1'b1;
            if (!wdata[0]) begin
                d.sfnm = 1'b0;
                d.aeoi = 1'b0;
            end
        end
        if (base_ld) d.base = wdata & BASE_KEEP;
        if (mode_ld) begin
            d.sfnm = wdata[4];
            d.aeoi = wdata[1];
        end
        if (mask_ld) d.mask = wdata;

        if (rd_en) begin
            d.rdata = rd_val;
            if (q.poll) begin
                d.poll    = 1'b0;
                d.isr_clr = poll_clr;
                d.irr_clr = poll_clr;
            end
        end

        if (poll_arm) d.poll = 1'b1;
        if (rsel_ld)  d.rsel = rsel_val;
        if (smm_ld)   d.smm  = smm_val;
        if (rot_ld)   d.rot  = rot_val;
        if (ofs_ld)   d.ofs  = ofs_val;
        if (eoi_vld)  d.isr_clr = d.isr_clr | lvl_bit(eoi_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rdata        = q.rdata;
    assign core_init    = q.core_init;
    assign mask_o       = q.mask;
    assign vec_base     = q.base;
    assign sfnm_en      = q.sfnm;
    assign aeoi_en      = q.aeoi;
    assign rot_aeoi_en  = q.rot;
    assign spec_mask_en = q.smm;
    assign prio_ofs     = q.ofs;
    assign isr_clr      = q.isr_clr;
    assign irr_clr      = q.irr_clr;
    assign st_cur       = q.st;
    assign poll_armed   = q.poll;
endmodule

// File: rtl/pic_cmd_ctrl_chk.sv
module pic_cmd_ctrl_chk
    import pic_cmd_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          a0,
    input logic [7:0]    wdata,
    input logic [7:0]    rdata,
    input logic          core_init,
    input logic [7:0]    mask_o,
    input logic [7:0]    vec_base,
    input logic [2:0]    prio_ofs,
    input logic [7:0]    isr_clr,
    input logic [7:0]    irr_clr,
    input logic          req_vld,
    input logic [2:0]    req_lvl,
    input init_st_e      st_cur,
    input logic          poll_armed
);
    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a0 && wdata[4]) |=> (core_init && mask_o == 8'h00 && prio_ofs == 3'd0));

    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a0 && st_cur == ST_BASE) |=> (vec_base == ($past(wdata) & 8'hF8)));

    p_cascade_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a0 && st_cur == ST_CASC) |=> ($stable(mask_o) && $stable(vec_base)));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a0 && st_cur == ST_RUN) |=> (mask_o == $past(wdata)));

    p_specific_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a0 && wdata[7:3] == 5'b01100 && !rd_en)
        |=> (isr_clr == (8'h01 << $past(wdata[2:0]))));

    p_read_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a0 && !poll_armed) |=> (rdata == $past(mask_o)));

    p_poll_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && req_vld) |=> (rdata == (8'h80 | {5'b0, $past(req_lvl)})));

    p_poll_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !wr_en) |=> !poll_armed);

    p_irr_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irr_clr));
endmodule

bind pic_cmd_ctrl pic_cmd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .a0         (a0),
    .wdata      (wdata),
    .rdata      (rdata),
    .core_init  (core_init),
    .mask_o     (mask_o),
    .vec_base   (vec_base),
    .prio_ofs   (prio_ofs),
    .isr_clr    (isr_clr),
    .irr_clr    (irr_clr),
    .req_vld    (req_vld),
    .req_lvl    (req_lvl),
    .st_cur     (st_cur),
    .poll_armed (poll_armed)
);

// File: tb/pic_cmd_ctrl_test.sv
module pic_cmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_RD   = 0;
    localparam int SEL_ISRC = 1;
    localparam int SEL_IRRC = 2;
    localparam int SEL_MASK = 3;
    localparam int SEL_BASE = 4;
    localparam int SEL_OFS  = 5;
    localparam int SEL_FLG  = 6;

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en, a0;
    logic [7:0] wdata;
    logic [7:0] rdata, mask_o, vec_base, isr_clr, irr_clr;
    logic       core_init, sfnm_en, aeoi_en, rot_aeoi_en, spec_mask_en;
    logic [2:0] prio_ofs;
    logic [7:0] core_irr, core_isr;
    logic       req_vld, isr_top_vld;
    logic [2:0] req_lvl, isr_top_lvl;

    item_t      exp_q[$];
    item_t      it;
    logic [7:0] got;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pic_cmd_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .a0           (a0),
        .wdata        (wdata),
        .rdata        (rdata),
        .core_init    (core_init),
        .mask_o       (mask_o),
        .vec_base     (vec_base),
        .sfnm_en      (sfnm_en),
        .aeoi_en      (aeoi_en),
        .rot_aeoi_en  (rot_aeoi_en),
        .spec_mask_en (spec_mask_en),
        .prio_ofs     (prio_ofs),
        .isr_clr      (isr_clr),
        .irr_clr      (irr_clr),
        .core_irr     (core_irr),
        .core_isr     (core_isr),
        .req_vld      (req_vld),
        .req_lvl      (req_lvl),
        .isr_top_vld  (isr_top_vld),
        .isr_top_lvl  (isr_top_lvl)
    );

    function automatic logic [7:0] pick(input int sel);
        case (sel)
            SEL_RD:   return rdata;
            SEL_ISRC: return isr_clr;
            SEL_IRRC: return irr_clr;
            SEL_MASK: return mask_o;
            SEL_BASE: return vec_base;
            SEL_OFS:  return {5'b0, prio_ofs};
            default:  return {3'b0, core_init, sfnm_en, aeoi_en, rot_aeoi_en, spec_mask_en};
        endcase
    endfunction

    // Monitor: results of the cycle just registered are compared at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                it  = exp_q.pop_front();
                got = pick(it.sel);
                n_chk++;
                if (got !== it.val) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, got, it.val);
                end
            end
        end
    end

    task automatic put(input int sel, input logic [7:0] val, input string tag);
        item_t e;
        e.sel = sel;
        e.val = val;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic addr, input logic [7:0] data);
        wr_en = 1'b1;
        rd_en = 1'b0;
        a0    = addr;
        wdata = data;
    endtask

    task automatic rd(input logic addr);
        wr_en = 1'b0;
        rd_en = 1'b1;
        a0    = addr;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; a0 = 1'b0; wdata = 8'h00;
        core_irr = 8'h3C; core_isr = 8'h41;
        req_vld = 1'b0; req_lvl = 3'd0; isr_top_vld = 1'b0; isr_top_lvl = 3'd0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        put(SEL_RD, 8'h00, "R11 rdata"); put(SEL_MASK, 8'h00, "R11 mask");
        put(SEL_BASE, 8'h00, "R11 base"); put(SEL_OFS, 8'h00, "R11 ofs");
        put(SEL_FLG, 8'h00, "R11 flags"); put(SEL_ISRC, 8'h00, "R11 isr_clr");
        put(SEL_IRRC, 8'h00, "R11 irr_clr");
        tick();

        // R1 / R2: sequence with the fourth word
        wr(1'b0, 8'h13); put(SEL_FLG, 8'h10, "R1 init pulse"); put(SEL_MASK, 8'h00, "R1 mask"); tick();
        wr(1'b1, 8'h4D); put(SEL_BASE, 8'h48, "R2 base"); put(SEL_FLG, 8'h00, "R1 pulse ends"); tick();
        wr(1'b1, 8'hFF); put(SEL_BASE, 8'h48, "R2 cascade base"); put(SEL_MASK, 8'h00, "R2 cascade mask"); tick();
        wr(1'b1, 8'h12); put(SEL_FLG, 8'h0C, "R2 mode word"); put(SEL_MASK, 8'h00, "R2 mode mask"); tick();

        // R3 / R9
        wr(1'b1, 8'hA5); put(SEL_MASK, 8'hA5, "R3 mask"); tick();
        rd(1'b1); put(SEL_RD, 8'hA5, "R9 mask read"); tick();
        rd(1'b0); put(SEL_RD, 8'h3C, "R9 request read"); tick();

        // R4 mode commands
        wr(1'b0, 8'h0B); tick();
        rd(1'b0); put(SEL_RD, 8'h41, "R4 select in-service"); tick();
        wr(1'b0, 8'h08); tick();
        rd(1'b0); put(SEL_RD, 8'h41, "R4 select held"); tick();
        wr(1'b0, 8'h68); put(SEL_FLG, 8'h0D, "R4 special mask set"); tick();
        wr(1'b0, 8'h48); put(SEL_FLG, 8'h0C, "R4 special mask clear"); tick();
        wr(1'b0, 8'h28); put(SEL_FLG, 8'h0C, "R4 special mask not enabled"); tick();

        // R5 rotation flag and no-op
        wr(1'b0, 8'h80); put(SEL_FLG, 8'h0E, "R5 rotate set"); tick();
        wr(1'b0, 8'h47); put(SEL_FLG, 8'h0E, "R5 nop flags"); put(SEL_ISRC, 8'h00, "R5 nop clr");
        put(SEL_OFS, 8'h00, "R5 nop ofs"); tick();
        wr(1'b0, 8'h00); put(SEL_FLG, 8'h0C, "R5 rotate clear"); tick();

        // R6 non-specific EOI
        isr_top_vld = 1'b1; isr_top_lvl = 3'd5;
        wr(1'b0, 8'h20); put(SEL_ISRC, 8'h20, "R6 eoi"); put(SEL_OFS, 8'h00, "R6 eoi ofs"); tick();
        put(SEL_ISRC, 8'h00, "R6 strobe one cycle"); tick();
        wr(1'b0, 8'hA0); put(SEL_ISRC, 8'h20, "R6 rotating eoi"); put(SEL_OFS, 8'h06, "R6 rotating ofs"); tick();
        isr_top_vld = 1'b0;
        wr(1'b0, 8'h20); put(SEL_ISRC, 8'h00, "R6 nothing in service"); tick();

        // R7 specific EOI
        wr(1'b0, 8'h63); put(SEL_ISRC, 8'h08, "R7 specific"); put(SEL_OFS, 8'h06, "R7 ofs kept"); tick();
        wr(1'b0, 8'hE7); put(SEL_ISRC, 8'h80, "R7 rotating specific"); put(SEL_OFS, 8'h00, "R7 ofs wrap"); tick();

        // R8 priority set
        wr(1'b0, 8'hC2); put(SEL_OFS, 8'h03, "R8 ofs"); put(SEL_ISRC, 8'h00, "R8 no clr"); tick();
        wr(1'b0, 8'hC7); put(SEL_OFS, 8'h00, "R8 ofs wrap"); tick();

        // R10 poll
        req_vld = 1'b1; req_lvl = 3'd4;
        wr(1'b0, 8'h0C); tick();
        rd(1'b1); put(SEL_RD, 8'h84, "R10 poll data"); put(SEL_IRRC, 8'h10, "R10 irr clr");
        put(SEL_ISRC, 8'h10, "R10 isr clr"); tick();
        rd(1'b1); put(SEL_RD, 8'hA5, "R10 poll disarmed"); put(SEL_IRRC, 8'h00, "R10 no second clr"); tick();
        req_vld = 1'b0;
        wr(1'b0, 8'h0C); tick();
        rd(1'b0); put(SEL_RD, 8'h07, "R10 poll empty"); put(SEL_ISRC, 8'h00, "R10 empty no clr"); tick();
        rd(1'b0); put(SEL_RD, 8'h41, "R10 normal after poll"); tick();

        // R1 / R2: sequence without the fourth word
        wr(1'b0, 8'hC2); put(SEL_OFS, 8'h03, "R8 ofs before init"); tick();
        wr(1'b0, 8'h10); put(SEL_FLG, 8'h10, "R1 flags cleared"); put(SEL_MASK, 8'h00, "R1 mask cleared");
        put(SEL_OFS, 8'h00, "R1 ofs cleared"); tick();
        rd(1'b0); put(SEL_RD, 8'h3C, "R1 select back to request"); tick();
        wr(1'b1, 8'h20); put(SEL_BASE, 8'h20, "R2 base second"); tick();
        wr(1'b1, 8'h00); put(SEL_MASK, 8'h00, "R2 cascade second"); tick();
        wr(1'b1, 8'h5A); put(SEL_MASK, 8'h5A, "R2 normal after cascade"); put(SEL_FLG, 8'h00, "R2 flags"); tick();

        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule